// File: doc/BRIEF.md
# Move instruction decoder with one-shot prefix

This block decodes the 16-bit instruction word of a core whose only operation is a move from a source to a destination. It splits the word into a format bit, a 7-bit destination field and an 8-bit source field. From these it produces the module and index of the destination register and an operand. The operand is either an immediate value or the module and index of a source register. Execution, the register file and arithmetic are outside the block. The decode paths are purely combinational from the presented word and the held prefix state.

A move whose source is an immediate and whose destination field equals the prefix location loads a one-byte prefix. The prefix applies to the next accepted instruction only. It supplies the upper byte of a 16-bit immediate and extra index bits for both register addresses, so every instruction remains a single fixed-size word. While a prefix is pending, the block holds off interrupt acceptance so that nothing can be inserted between the prefix and the instruction it modifies.

Top module: `move_decoder`

## Requirements
- R1: Field split. Bit 15 is the format bit. Bits 14:8 are the destination field and bits 7:0 are the source field. The destination module is bits 11:8 and the low three destination index bits are bits 14:12. The source module is bits 3:0 and the low four source index bits are bits 7:4.
- R2: Format 0 selects an immediate: `src_is_reg` is 0 and `imm_val[7:0]` equals bits 7:0. Format 1 selects a register: `src_is_reg` is 1 and `imm_val` is zero.
- R3: With no prefix pending, `imm_val[15:8]` is zero, `dst_idx[4:3]` is zero and `src_idx[4]` is zero.
- R4: A prefix load occurs when `instr_valid` is 1, bit 15 is 0 and bits 14:8 equal 0x0B. In that cycle `pfx_take` is 1, and from the next clock `pfx_active` is 1 with the loaded byte equal to bits 7:0.
- R5: While a prefix byte P is pending, a format-0 word decodes `imm_val` as {P, bits 7:0}.
- R6: While a prefix byte P is pending, `dst_idx[4:3]` equals P[1:0] and `src_idx[4]` equals P[4].
- R7: Any accepted instruction that is not a prefix load clears the prefix at the next clock. Cycles with `instr_valid` at 0 leave the prefix state unchanged.
- R8: A prefix load while a prefix is pending replaces it with the new byte.
- R9: A format-1 move to the prefix location does not load a prefix: `pfx_take` stays 0, and the pending prefix, if any, is cleared.
- R10: `irq_hold` is 1 exactly while a prefix is pending.
- R11: `dst_sys` is 1 when the destination module is below 6. `src_sys` is 1 when format is 1 and the source module is below 6.
- R12: After reset no prefix is pending: `pfx_active` and `irq_hold` are 0 and the extension bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Word is accepted for execution this cycle |
| instr_word | input | 16 | Instruction word |
| dst_mod | output | 4 | Destination module number |
| dst_idx | output | 5 | Destination index, prefix-extended |
| dst_sys | output | 1 | Destination lies in a system module |
| src_mod | output | 4 | Source module number |
| src_idx | output | 5 | Source index, prefix-extended |
| src_sys | output | 1 | Register source lies in a system module |
| src_is_reg | output | 1 | Operand is a register (1) or immediate (0) |
| imm_val | output | 16 | Immediate operand |
| pfx_take | output | 1 | This accepted word loads the prefix |
| pfx_active | output | 1 | A prefix is pending for the next instruction |
| irq_hold | output | 1 | Interrupt acceptance must be deferred |

## Verification
The bench sweeps all 65536 words with no prefix pending. A decoder that leaks stale prefix bits, or that swaps the module and index halves, shows up there. Every prefix byte value is then loaded and followed by both an immediate and a register word. That catches a wrong byte lane or wrong extension bit positions in the immediate or the indices. Three sequences target the prefix lifetime: idle cycles between a prefix and its user, back-to-back prefixes, and a register-sourced move to the prefix location. A design that clears on idle cycles, keeps the first byte, or loads from a register move would produce a wrong upper immediate byte or a wrong `irq_hold`.

// File: rtl/move_decoder.sv
module move_decoder #(
  parameter logic [6:0] PFX_DST  = 7'h0B,
  parameter int         SYS_MODS = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instr_valid,
  input  logic [15:0] instr_word,
  output logic [3:0]  dst_mod,
  output logic [4:0]  dst_idx,
  output logic        dst_sys,
  output logic [3:0]  src_mod,
  output logic [4:0]  src_idx,
  output logic        src_sys,
  output logic        src_is_reg,
  output logic [15:0] imm_val,
  output logic        pfx_take,
  output logic        pfx_active,
  output logic        irq_hold
);

  logic       fmt;
  logic [6:0] dfield;
  logic [7:0] sfield;
  logic [7:0] pfx_q;
  logic [7:0] pfx_eff;

  assign fmt    = instr_word[15];
  assign dfield = instr_word[14:8];
  assign sfield = instr_word[7:0];

  assign pfx_eff = pfx_active ? pfx_q : 8'h00;

  assign dst_mod = dfield[3:0];
  assign dst_idx = {pfx_eff[1:0], dfield[6:4]};
  assign dst_sys = (32'(dfield[3:0]) < SYS_MODS);

  assign src_mod    = sfield[3:0];
  assign src_idx    = {pfx_eff[4], sfield[7:4]};
  assign src_is_reg = fmt;
  assign src_sys    = fmt && (32'(sfield[3:0]) < SYS_MODS);
  assign imm_val    = fmt ? 16'h0000 : {pfx_eff, sfield};

  assign pfx_take = instr_valid && !fmt && (dfield == PFX_DST);
  assign irq_hold = pfx_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfx_q      <= 8'h00;
      pfx_active <= 1'b0;
    end else if (instr_valid) begin
      if (pfx_take) begin
        pfx_q      <= sfield;
        pfx_active <= 1'b1;
      end else begin
        pfx_q      <= 8'h00;
        pfx_active <= 1'b0;
      end
    end
  end

  a_r4_prefix_loads: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_take |=> pfx_active && imm_val[15:8] == ($past(sfield) & {8{!fmt}}));

  a_r7_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !pfx_take) |=> !pfx_active);

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(pfx_active) && $stable(dst_idx[4:3]));

  a_r3_no_prefix_upper: assert property (@(posedge clk) disable iff (!rst_n)
    !pfx_active |-> imm_val[15:8] == 8'h00 && dst_idx[4:3] == 2'b00 && !src_idx[4]);

  a_r9_reg_move_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && fmt) |=> !pfx_active);

  a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_hold) |-> $past(instr_valid));

endmodule

// File: tb/test_move_decoder.sv
module test_move_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr_word = 16'h0000;
  logic [3:0]  dst_mod, src_mod;
  logic [4:0]  dst_idx, src_idx;
  logic        dst_sys, src_sys, src_is_reg, pfx_take, pfx_active, irq_hold;
  logic [15:0] imm_val;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_p = 8'h00;
  logic       m_pv = 1'b0;

  always #2 clk = ~clk;

  move_decoder i_move_decoder (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .dst_mod(dst_mod), .dst_idx(dst_idx), .dst_sys(dst_sys),
    .src_mod(src_mod), .src_idx(src_idx), .src_sys(src_sys),
    .src_is_reg(src_is_reg), .imm_val(imm_val), .pfx_take(pfx_take),
    .pfx_active(pfx_active), .irq_hold(irq_hold));

  task automatic check_all(input string tag);
    logic [7:0]  ep;
    logic [15:0] w;
    logic [39:0] exp_v, act_v;
    w  = instr_word;
    ep = m_pv ? m_p : 8'h00;
    exp_v = {w[11:8], ep[1:0], w[14:12], (w[11:8] < 4'd6),
             w[3:0], ep[4], w[7:4], (w[15] && w[3:0] < 4'd6), w[15],
             (w[15] ? 16'h0000 : {ep, w[7:0]}),
             (instr_valid && !w[15] && w[14:8] == 7'h0B), m_pv, m_pv};
    act_v = {dst_mod, dst_idx, dst_sys, src_mod, src_idx, src_sys, src_is_reg,
             imm_val, pfx_take, pfx_active, irq_hold};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s word=%h actual=%h expected=%h", tag, w, act_v, exp_v);
    end
  endtask

  task automatic drive(input logic v, input logic [15:0] w, input string tag);
    @(negedge clk);
    instr_valid = v;
    instr_word  = w;
    #1;
    check_all(tag);
    if (v) begin
      if (!w[15] && w[14:8] == 7'h0B) begin
        m_p = w[7:0]; m_pv = 1'b1;
      end else begin
        m_p = 8'h00;  m_pv = 1'b0;
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 16'h7FFF, "R12 reset state");

    for (int w = 0; w < 65536; w++)
      drive(1'b0, 16'(w), "R1 R2 R3 R11 sweep without prefix");

    for (int p = 0; p < 256; p++) begin
      drive(1'b1, {1'b0, 7'h0B, 8'(p)}, "R4 prefix load");
      drive(1'b0, {1'b0, 7'h35, 8'(255 - p)}, "R4 R10 prefix pending");
      drive(1'b1, {1'b0, 7'h5A, 8'(p ^ 8'h5C)}, "R5 R6 immediate with prefix");
      drive(1'b1, {1'b0, 7'h0B, 8'(p)}, "R4 prefix reload");
      drive(1'b1, {1'b1, 7'h73, 8'(p ^ 8'hA3)}, "R6 register with prefix");
      drive(1'b0, {1'b0, 7'h21, 8'h99}, "R7 prefix cleared after use");
    end

    drive(1'b1, 16'h0B12, "R4 first prefix");
    drive(1'b1, 16'h0BF3, "R8 second prefix replaces");
    drive(1'b1, 16'h4466, "R8 immediate uses second prefix");
    drive(1'b0, 16'h4466, "R7 cleared");

    drive(1'b1, 16'h0BFF, "R4 prefix before register move");
    drive(1'b1, 16'h8B07, "R9 register move to prefix location");
    drive(1'b1, 16'h0177, "R9 no prefix after register move");

    drive(1'b1, 16'h8B07, "R9 register move does not load");
    drive(1'b0, 16'h0001, "R9 still idle");

    drive(1'b1, 16'h0B55, "R4 prefix load");
    drive(1'b0, 16'h1234, "R7 idle keeps prefix");
    drive(1'b0, 16'h9234, "R7 idle keeps prefix");
    drive(1'b1, 16'h1234, "R5 R10 prefix survives idle");
    drive(1'b0, 16'h1234, "R7 one-shot clear");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule